// File: doc/BRIEF.md
# Floating-Point Rounding Stage

This block sits after the normalizer in a single-precision floating-point datapath. It takes a sign, a biased 8-bit exponent, a 24-bit significand with the leading (hidden) bit present, and a tail of low-order bits that fell off the end of that significand. It also takes a two-bit code that selects one of the four standard rounding directions. From the tail it derives the round bit and the sticky bit. It then decides whether to add one unit in the last place, renormalizes when that addition ripples out of the top, and packs the sign, exponent and fraction into a 32-bit word. Alongside the word it raises an inexact flag and an overflow flag.

The stage has no handshake. With the default setting, every clock edge captures one operand and the packed result appears one cycle later. A parameter removes that register and leaves a purely combinational path. Inputs whose exponent field is all ones are carried through untouched. Inputs whose exponent field is zero are subnormal: they round like any other value, and when a subnormal rounds up into the hidden-bit position it is promoted to the smallest normal exponent.

Top module: `fp_round_stage`

## Requirements
- R1: The most significant tail bit is the round bit. The sticky bit is the OR of every other tail bit. A finite input with an all-zero tail comes out with its sign, exponent and fraction unchanged and with both flags low.
- R2: With mode code 00 (nearest, ties to even), the significand is incremented when the round bit is 1 and either the sticky bit or the significand's least significant bit is 1. Otherwise it is truncated.
- R3: With mode code 01 (toward zero), the significand is always truncated.
- R4: With mode code 10 (toward plus infinity), the significand is incremented only when the sign is 0 and the round or sticky bit is 1.
- R5: With mode code 11 (toward minus infinity), the significand is incremented only when the sign is 1 and the round or sticky bit is 1.
- R6: When the increment carries out of an all-ones significand, the output fraction is zero and the exponent is one higher than the input exponent.
- R7: When rounding brings the exponent to 255, the overflow flag is 1 and the word is infinity: exponent 255, fraction 0, input sign.
- R8: For an input with an exponent below 255, the inexact flag equals the OR of the round bit and the sticky bit.
- R9: An input with exponent 255 is emitted unchanged (sign, exponent, the low 23 significand bits) with both flags low, whatever the mode and tail.
- R10: An input with exponent 0 whose significand rounds up into bit 23 is emitted with exponent 1. A subnormal that stays below bit 23 keeps exponent 0.
- R11: The word carries the sign in bit 31, the exponent in bits 30..23 and the fraction in bits 22..0. With the output register present (the default), results appear one clock after the inputs, and reset clears the word and both flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| signIn | input | 1 | Sign of the value to round |
| expIn | input | EXP_W (8) | Biased exponent |
| sigIn | input | SIG_W (24) | Normalized significand, hidden bit in the MSB |
| tailIn | input | TAIL_W (24) | Discarded low-order bits, round bit in the MSB |
| modeIn | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| result | output | EXP_W+SIG_W (32) | Packed sign, exponent and fraction |
| inexact | output | 1 | Precision was lost |
| overflow | output | 1 | Rounding reached the infinity exponent |

## Verification
The hardest outcomes to produce are the two that depend on a carry rippling through all 24 significand bits: renormalization, and overflow into infinity. A random operand almost never has an all-ones significand, and it is even less likely to have that significand with exponent 254 and a tail that triggers an increment in the chosen mode. Directed tasks therefore build these operands explicitly. Each one is driven under every mode and both signs, so the same all-ones value is seen both truncated and carried out. The same approach drives a subnormal whose fraction is all ones into the hidden bit, and exact ties with even and odd last bits.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  // Rounding direction codes as seen on the mode input
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_TO_ZERO   = 2'b01,
    RND_TO_POS    = 2'b10,
    RND_TO_NEG    = 2'b11
  } rndMode_e;

  // Observations the datapath hands to the decision logic
  typedef struct packed {
    logic lastBit;    // least significant kept significand bit
    logic roundBit;   // first discarded bit
    logic stickyBit;  // OR of the remaining discarded bits
    logic special;    // exponent field is all ones
  } rndStatus_t;

  // Strobes the decision logic returns to the datapath
  typedef struct packed {
    logic bumpSig;      // add one unit in the last place
    logic markInexact;  // precision was lost
    logic passThru;     // forward operand untouched
  } rndCtrl_t;

endpackage

// File: rtl/fp_round_ctrl.sv
module fp_round_ctrl
  import fp_round_pkg::*;
(
  input  logic       signIn,
  input  logic [1:0] modeIn,
  input  rndStatus_t stat,
  output rndCtrl_t   ctrl
);

  logic     anyLost;
  logic     wantUp;
  rndMode_e modeSel;

  assign modeSel = rndMode_e'(modeIn);
  assign anyLost = stat.roundBit | stat.stickyBit;

  // Direction decision: nearest-even looks at the tie and the last bit,
  // the directed modes look only at the sign and whether anything was lost.
  always_comb begin
    case (modeSel)
      RND_NEAR_EVEN: wantUp = stat.roundBit & (stat.stickyBit | stat.lastBit);
      RND_TO_ZERO:   wantUp = 1'b0;
      RND_TO_POS:    wantUp = ~signIn & anyLost;
      RND_TO_NEG:    wantUp = signIn & anyLost;
      default:       wantUp = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.passThru    = stat.special;
    ctrl.bumpSig     = wantUp & ~stat.special;
    ctrl.markInexact = anyLost & ~stat.special;
  end

endmodule

// File: rtl/fp_round_dp.sv
module fp_round_dp
  import fp_round_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int SIG_W  = 24,
  parameter int TAIL_W = 24
) (
  input  logic                   signIn,
  input  logic [EXP_W-1:0]       expIn,
  input  logic [SIG_W-1:0]       sigIn,
  input  logic [TAIL_W-1:0]      tailIn,
  input  rndCtrl_t               ctrl,
  output rndStatus_t             stat,
  output logic [EXP_W+SIG_W-1:0] word,
  output logic                   ovfFlag,
  output logic                   inxFlag
);

  localparam int FRAC_W = SIG_W - 1;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(1);

  logic             roundBit;
  logic             stickyBit;
  logic [SIG_W:0]   sumSig;
  logic             carryOut;
  logic [FRAC_W-1:0] keptFrac;
  logic [EXP_W-1:0] expNext;
  logic             hitMax;

  // Round bit is the tail MSB; the sticky bit collapses whatever remains.
  assign roundBit = tailIn[TAIL_W-1];
  generate
    if (TAIL_W > 1) begin : g_sticky
      assign stickyBit = |tailIn[TAIL_W-2:0];
    end else begin : g_noSticky
      assign stickyBit = 1'b0;
    end
  endgenerate

  always_comb begin
    stat.lastBit   = sigIn[0];
    stat.roundBit  = roundBit;
    stat.stickyBit = stickyBit;
    stat.special   = (expIn == EXP_MAX);
  end

  // Increment with one extra bit to catch a ripple out of the top
  assign sumSig   = {1'b0, sigIn} + {{SIG_W{1'b0}}, ctrl.bumpSig};
  assign carryOut = sumSig[SIG_W];

  // On carry the significand is 1.000..., so the shifted fraction is zero
  assign keptFrac = carryOut ? sumSig[SIG_W-1:1] : sumSig[FRAC_W-1:0];

  always_comb begin
    if (carryOut) begin
      expNext = expIn + EXP_ONE;
    end else if (expIn == '0) begin
      // subnormal promoted when rounding fills the hidden position
      expNext = {{(EXP_W-1){1'b0}}, sumSig[SIG_W-1]};
    end else begin
      expNext = expIn;
    end
  end

  assign hitMax = (expNext == EXP_MAX) & ~ctrl.passThru;

  always_comb begin
    if (ctrl.passThru) begin
      word = {signIn, expIn, sigIn[FRAC_W-1:0]};
    end else if (hitMax) begin
      word = {signIn, EXP_MAX, {FRAC_W{1'b0}}};
    end else begin
      word = {signIn, expNext, keptFrac};
    end
  end

  assign ovfFlag = hitMax;
  assign inxFlag = ctrl.markInexact;

endmodule

// File: rtl/fp_round_stage.sv
module fp_round_stage
  import fp_round_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int SIG_W   = 24,
  parameter int TAIL_W  = 24,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   signIn,
  input  logic [EXP_W-1:0]       expIn,
  input  logic [SIG_W-1:0]       sigIn,
  input  logic [TAIL_W-1:0]      tailIn,
  input  logic [1:0]             modeIn,
  output logic [EXP_W+SIG_W-1:0] result,
  output logic                   inexact,
  output logic                   overflow
);

  localparam int WORD_W = EXP_W + SIG_W;

  rndStatus_t        stat;
  rndCtrl_t          ctrl;
  logic [WORD_W-1:0] wordComb;
  logic              ovfComb;
  logic              inxComb;

  fp_round_ctrl u_ctrl (
    .signIn (signIn),
    .modeIn (modeIn),
    .stat   (stat),
    .ctrl   (ctrl)
  );

  fp_round_dp #(
    .EXP_W  (EXP_W),
    .SIG_W  (SIG_W),
    .TAIL_W (TAIL_W)
  ) u_dp (
    .signIn  (signIn),
    .expIn   (expIn),
    .sigIn   (sigIn),
    .tailIn  (tailIn),
    .ctrl    (ctrl),
    .stat    (stat),
    .word    (wordComb),
    .ovfFlag (ovfComb),
    .inxFlag (inxComb)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result   <= '0;
          inexact  <= 1'b0;
          overflow <= 1'b0;
        end else begin
          result   <= wordComb;
          inexact  <= inxComb;
          overflow <= ovfComb;
        end
      end
    end else begin : g_comb
      assign result   = wordComb;
      assign inexact  = inxComb;
      assign overflow = ovfComb;
    end
  endgenerate

endmodule

// File: rtl/fp_round_stage_chk.sv
module fp_round_stage_chk #(
  parameter int EXP_W   = 8,
  parameter int SIG_W   = 24,
  parameter int TAIL_W  = 24,
  parameter bit REG_OUT = 1'b1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   signIn,
  input logic [EXP_W-1:0]       expIn,
  input logic [SIG_W-1:0]       sigIn,
  input logic [TAIL_W-1:0]      tailIn,
  input logic [1:0]             modeIn,
  input logic [EXP_W+SIG_W-1:0] result,
  input logic                   inexact,
  input logic                   overflow
);

  localparam int WORD_W = EXP_W + SIG_W;
  localparam int FRAC_W = SIG_W - 1;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  generate
    if (REG_OUT) begin : g_seqChecks
      AST_RESET_CLEAR: assert property (@(posedge clk)
        !rstN |=> (result == '0 && !inexact && !overflow)); // R11

      AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> result[WORD_W-1] == $past(signIn)); // R11

      AST_EXACT_UNCHANGED: assert property (@(posedge clk) disable iff (!rstN)
        (tailIn == '0 && expIn != EXP_MAX && expIn != '0)
        |=> (result == $past({signIn, expIn, sigIn[FRAC_W-1:0]}) && !inexact && !overflow)); // R1

      AST_TOWARD_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (modeIn == 2'b01 && expIn != EXP_MAX && expIn != '0)
        |=> result[WORD_W-2:0] == $past({expIn, sigIn[FRAC_W-1:0]})); // R3

      AST_INEXACT_TRACK: assert property (@(posedge clk) disable iff (!rstN)
        (expIn != EXP_MAX) |=> inexact == $past(|tailIn)); // R8

      AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (!rstN)
        (expIn == EXP_MAX)
        |=> (result == $past({signIn, expIn, sigIn[FRAC_W-1:0]}) && !inexact && !overflow)); // R9

      AST_OVF_INF: assert property (@(posedge clk) disable iff (!rstN)
        overflow |-> (result[WORD_W-2:FRAC_W] == EXP_MAX && result[FRAC_W-1:0] == '0 && inexact)); // R7
    end
  endgenerate

endmodule

bind fp_round_stage fp_round_stage_chk #(
  .EXP_W   (EXP_W),
  .SIG_W   (SIG_W),
  .TAIL_W  (TAIL_W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .signIn   (signIn),
  .expIn    (expIn),
  .sigIn    (sigIn),
  .tailIn   (tailIn),
  .modeIn   (modeIn),
  .result   (result),
  .inexact  (inexact),
  .overflow (overflow)
);

// File: tb/fp_round_stage_test.sv
module fp_round_stage_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        signIn = 1'b0;
  logic [7:0]  expIn = '0;
  logic [23:0] sigIn = '0;
  logic [23:0] tailIn = '0;
  logic [1:0]  modeIn = '0;
  logic [31:0] result;
  logic        inexact;
  logic        overflow;

  int vecCount = 0;
  int missCount = 0;

  always #2.5 clk = ~clk;

  fp_round_stage uut (
    .clk      (clk),
    .rstN     (rstN),
    .signIn   (signIn),
    .expIn    (expIn),
    .sigIn    (sigIn),
    .tailIn   (tailIn),
    .modeIn   (modeIn),
    .result   (result),
    .inexact  (inexact),
    .overflow (overflow)
  );

  // Reference built from the requirement text: {overflow, inexact, word}
  function automatic logic [33:0] refRound(input logic s, input logic [7:0] e,
      input logic [23:0] m, input logic [23:0] t, input logic [1:0] md);
    logic r, st, up, ovf;
    logic [24:0] acc;
    int ex;
    if (e == 8'hFF) return {2'b00, s, e, m[22:0]};
    r  = t[23];
    st = |t[22:0];
    case (md)
      2'd0:    up = r && (st || m[0]);
      2'd1:    up = 1'b0;
      2'd2:    up = !s && (r || st);
      default: up = s && (r || st);
    endcase
    acc = {1'b0, m} + 25'(up);
    ex  = e;
    if (acc[24]) begin
      acc = acc >> 1;
      ex  = ex + 1;
    end else if (e == 8'd0 && acc[23]) begin
      ex = 1;
    end
    ovf = (ex == 255);
    return {ovf, (r || st), s, 8'(ex), ovf ? 23'd0 : acc[22:0]};
  endfunction

  task automatic apply(input logic s, input logic [7:0] e, input logic [23:0] m,
                       input logic [23:0] t, input logic [1:0] md);
    @(negedge clk);
    signIn = s; expIn = e; sigIn = m; tailIn = t; modeIn = md;
    @(negedge clk);
  endtask

  task automatic expectOut(input string req, input logic [31:0] w,
                           input logic inx, input logic ovf);
    vecCount++;
    if (result !== w || inexact !== inx || overflow !== ovf) begin
      missCount++;
      $display("FAIL %s: got word=%h inx=%b ovf=%b, expected word=%h inx=%b ovf=%b",
               req, result, inexact, overflow, w, inx, ovf);
    end
  endtask

  task automatic runRef(input string req, input logic s, input logic [7:0] e,
                        input logic [23:0] m, input logic [23:0] t, input logic [1:0] md);
    logic [33:0] exp34;
    exp34 = refRound(s, e, m, t, md);
    apply(s, e, m, t, md);
    expectOut(req, exp34[31:0], exp34[32], exp34[33]);
  endtask

  task automatic testReset();
    signIn = 1'b1; expIn = 8'd200; sigIn = 24'hFFFFFF; tailIn = 24'hFFFFFF; modeIn = 2'd3;
    repeat (2) @(negedge clk);
    expectOut("R11 reset", 32'h0, 1'b0, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic testExact();
    apply(1'b0, 8'd130, 24'hABCDEF, 24'h0, 2'd2);
    expectOut("R1 exact", {1'b0, 8'd130, 23'h2BCDEF}, 1'b0, 1'b0);
    // sticky alone (deep bit) counts as loss
    apply(1'b0, 8'd130, 24'h800000, 24'h000001, 2'd2);
    expectOut("R1 sticky", {1'b0, 8'd130, 23'h000001}, 1'b1, 1'b0);
  endtask

  task automatic testNearestEven();
    apply(1'b0, 8'd100, 24'h800000, 24'h800000, 2'd0);
    expectOut("R2 tie even", {1'b0, 8'd100, 23'h0}, 1'b1, 1'b0);
    apply(1'b0, 8'd100, 24'h800001, 24'h800000, 2'd0);
    expectOut("R2 tie odd", {1'b0, 8'd100, 23'h2}, 1'b1, 1'b0);
    apply(1'b1, 8'd100, 24'h800000, 24'h800001, 2'd0);
    expectOut("R2 above half", {1'b1, 8'd100, 23'h1}, 1'b1, 1'b0);
    apply(1'b0, 8'd100, 24'h800001, 24'h7FFFFF, 2'd0);
    expectOut("R2 below half", {1'b0, 8'd100, 23'h1}, 1'b1, 1'b0);
  endtask

  task automatic testDirected();
    apply(1'b0, 8'd90, 24'h900000, 24'h000002, 2'd2);
    expectOut("R4 pos up", {1'b0, 8'd90, 23'h100001}, 1'b1, 1'b0);
    apply(1'b1, 8'd90, 24'h900000, 24'h000002, 2'd2);
    expectOut("R4 neg keep", {1'b1, 8'd90, 23'h100000}, 1'b1, 1'b0);
    apply(1'b1, 8'd90, 24'h900000, 24'h400000, 2'd3);
    expectOut("R5 neg up", {1'b1, 8'd90, 23'h100001}, 1'b1, 1'b0);
    apply(1'b0, 8'd90, 24'h900000, 24'h400000, 2'd3);
    expectOut("R5 pos keep", {1'b0, 8'd90, 23'h100000}, 1'b1, 1'b0);
    apply(1'b1, 8'd90, 24'hFFFFFF, 24'hFFFFFF, 2'd1);
    expectOut("R3 truncate", {1'b1, 8'd90, 23'h7FFFFF}, 1'b1, 1'b0);
  endtask

  task automatic testCarry();
    apply(1'b0, 8'd120, 24'hFFFFFF, 24'h000001, 2'd2);
    expectOut("R6 carry renorm", {1'b0, 8'd121, 23'h0}, 1'b1, 1'b0);
    apply(1'b0, 8'd120, 24'hFFFFFF, 24'h000001, 2'd0);
    expectOut("R6 no carry rne", {1'b0, 8'd120, 23'h7FFFFF}, 1'b1, 1'b0);
  endtask

  task automatic testOverflow();
    apply(1'b1, 8'd254, 24'hFFFFFF, 24'h800000, 2'd0);
    expectOut("R7 overflow", {1'b1, 8'hFF, 23'h0}, 1'b1, 1'b1);
    apply(1'b0, 8'd254, 24'hFFFFFF, 24'h800000, 2'd1);
    expectOut("R7 max kept", {1'b0, 8'd254, 23'h7FFFFF}, 1'b1, 1'b0);
  endtask

  task automatic testSubnormal();
    apply(1'b0, 8'd0, 24'h7FFFFF, 24'hC00000, 2'd0);
    expectOut("R10 promote", {1'b0, 8'd1, 23'h0}, 1'b1, 1'b0);
    apply(1'b0, 8'd0, 24'h000010, 24'hC00000, 2'd0);
    expectOut("R10 stay subnormal", {1'b0, 8'd0, 23'h11}, 1'b1, 1'b0);
  endtask

  task automatic testSpecial();
    apply(1'b0, 8'hFF, 24'hC00001, 24'hFFFFFF, 2'd2);
    expectOut("R9 nan pass", {1'b0, 8'hFF, 23'h400001}, 1'b0, 1'b0);
    apply(1'b1, 8'hFF, 24'h800000, 24'h800000, 2'd0);
    expectOut("R9 inf pass", {1'b1, 8'hFF, 23'h0}, 1'b0, 1'b0);
  endtask

  task automatic testSweep();
    string tags[4] = '{"R2 sweep", "R3 sweep", "R4 sweep", "R5 sweep"};
    logic [23:0] sigs[3] = '{24'hFFFFFF, 24'h800001, 24'hA5A5A4};
    logic [23:0] tails[3] = '{24'h800000, 24'h000100, 24'h7FFFFF};
    for (int md = 0; md < 4; md++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 3; k++) begin
          runRef(tags[md], 1'(s), 8'd254 - 8'(k), sigs[k], tails[k], 2'(md));
        end
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    missCount++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    testReset();
    testExact();
    testNearestEven();
    testDirected();
    testCarry();
    testOverflow();
    testSubnormal();
    testSpecial();
    testSweep();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule